// File: doc/BRIEF.md
# Receive Endpoint DMA Drain Controller

This block sits between the packet receiver of a bulk-out USB endpoint and a byte-wide DMA engine. It holds two 64-byte banks. The receiver fills them in strict alternation, one byte per write strobe, and closes each packet with an end strobe. The number of bytes written becomes the bank's byte count. The drain side reads the selected bank. In DMA mode the block asks for service while that bank still holds unread bytes and hands out one byte for each acknowledge.

The drain side releases a bank in one of two ways. In DMA mode the block releases the bank itself when the last byte is taken, whatever the packet length, and then moves to the other bank. A zero-length packet never occupies a bank in this mode. Software must not send a read-done command while DMA mode is on. If it does, the block flags a protocol error and does nothing else. In CPU mode, software reads bytes with a read strobe and frees the bank with the read-done strobe. No automatic release happens in this mode.

Top module: `rx_dma_drain`

## Requirements
- R1: `dma_req_o` is high exactly when `dma_en_i` is high and the selected bank is full with at least one unread byte.
- R2: Each accepted pop consumes one byte. In DMA mode a pop is `dma_ack_i` while a byte is pending. In CPU mode it is `cpu_rd_i` while a byte is pending. `rd_data_o` shows the next unread byte, and bytes come out in the order they were written. An acknowledge or read with nothing pending is ignored.
- R3: In DMA mode, popping the last byte of the selected bank frees that bank and selects the other one at the same edge. `auto_rel_o` is high for the following cycle. This applies to any length from 1 to 64.
- R4: A 150-byte transfer, sent as 64, 64 and 22 byte packets and drained by DMA, gives exactly three `auto_rel_o` pulses and leaves both banks empty.
- R5: In DMA mode, an end strobe with no bytes in the packet is discarded. No bank becomes full and no request is raised.
- R6: `cpu_done_i` while `dma_en_i` is high makes `proto_err_o` high for the following cycle. It changes no bank and no read position.
- R7: In CPU mode, reading every byte leaves the bank full. `cpu_done_i` on a full selected bank frees it and selects the other bank.
- R8: `wr_ready_o` is low while both banks are full. Write and end strobes in that state are ignored.
- R9: Bytes beyond 64 in one packet are dropped, so the byte count saturates at 64.
- R10: After reset both banks are empty, `wr_ready_o` is high, and `dma_req_o`, `rx_full_o`, `auto_rel_o` and `proto_err_o` are low.
- R11: In CPU mode a zero-length packet is committed. The bank becomes full with `rx_cnt_o` equal to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dma_en_i | input | 1 | 1 selects DMA mode, 0 selects CPU mode |
| wr_valid_i | input | 1 | Receiver byte write strobe |
| wr_data_i | input | 8 | Receiver byte |
| pkt_end_i | input | 1 | Closes the current packet (may coincide with a last byte) |
| wr_ready_o | output | 1 | Fill bank is free |
| dma_ack_i | input | 1 | DMA byte acknowledge |
| cpu_rd_i | input | 1 | CPU byte read strobe |
| cpu_done_i | input | 1 | CPU read-done command |
| dma_req_o | output | 1 | DMA service request |
| rd_data_o | output | 8 | Next unread byte of the selected bank |
| rx_full_o | output | 1 | Selected bank is full |
| rx_cnt_o | output | 7 | Byte count of the selected bank (valid while full) |
| auto_rel_o | output | 1 | One-cycle pulse after an automatic release |
| proto_err_o | output | 1 | One-cycle pulse after a read-done command in DMA mode |

## Verification
`dma_req_o`, `rd_data_o`, `rx_full_o`, `rx_cnt_o` and `wr_ready_o` are decoded from registered state. Each reflects a write, end strobe or pop in the cycle right after the edge that takes that stimulus. `auto_rel_o` and `proto_err_o` are registered and appear in that same cycle, one edge after their cause. The bench drives inputs on the falling edge and compares every output 1 ns later against a queue model that it advances at each rising edge. This way each result is checked in the cycle it is due, and never earlier.

// File: rtl/rx_dma_pkg.sv
package rx_dma_pkg;
  localparam int NUM_BANKS = 2;
  typedef logic bank_sel_t;

  function automatic bank_sel_t other_bank(bank_sel_t b);
    return ~b;
  endfunction
endpackage

// File: rtl/rx_fill_ctrl.sv
module rx_fill_ctrl
  import rx_dma_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CNT_W = $clog2(DEPTH + 1),
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 dma_en_i,
  input  logic                 wr_valid_i,
  input  logic                 pkt_end_i,
  input  logic [NUM_BANKS-1:0] bank_full_i,
  output logic                 wr_ready_o,
  output logic                 wr_en_o,
  output logic [IDX_W-1:0]     wr_idx_o,
  output bank_sel_t            fill_bank_o,
  output logic                 commit_o,
  output logic [CNT_W-1:0]     commit_cnt_o
);
  bank_sel_t        fp_q;
  logic [CNT_W-1:0] wcnt_q;
  logic             end_ok, drop;

  assign wr_ready_o   = !bank_full_i[fp_q];
  assign wr_en_o      = wr_valid_i && wr_ready_o && (wcnt_q < CNT_W'(DEPTH));
  assign wr_idx_o     = wcnt_q[IDX_W-1:0];
  assign fill_bank_o  = fp_q;
  assign commit_cnt_o = wcnt_q + CNT_W'(wr_en_o);
  assign end_ok       = pkt_end_i && wr_ready_o;
  // zero-length packets never occupy a bank in DMA mode
  assign drop         = end_ok && dma_en_i && (commit_cnt_o == '0);
  assign commit_o     = end_ok && !drop;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fp_q   <= 1'b0;
      wcnt_q <= '0;
    end else if (end_ok) begin
      wcnt_q <= '0;
      if (commit_o) fp_q <= other_bank(fp_q);
    end else if (wr_en_o) begin
      wcnt_q <= wcnt_q + CNT_W'(1);
    end
  end

  assert_zlp_keeps_bank_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_end_i && dma_en_i && wr_ready_o && wcnt_q == '0 && !wr_valid_i) |=> fp_q == $past(fp_q));
  assert_no_fill_when_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_ready_o |=> wcnt_q == $past(wcnt_q));
endmodule

// File: rtl/rx_bank_store.sv
module rx_bank_store
  import rx_dma_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64,
  parameter int CNT_W  = $clog2(DEPTH + 1),
  parameter int IDX_W  = $clog2(DEPTH)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  bank_sel_t            fill_bank_i,
  input  logic [IDX_W-1:0]     wr_idx_i,
  input  logic [DATA_W-1:0]    wr_data_i,
  input  logic                 commit_i,
  input  logic [CNT_W-1:0]     commit_cnt_i,
  input  logic                 release_i,
  input  bank_sel_t            sel_i,
  input  logic [IDX_W-1:0]     rd_idx_i,
  output logic [NUM_BANKS-1:0] full_o,
  output logic [CNT_W-1:0]     cnt_sel_o,
  output logic [DATA_W-1:0]    rd_data_o
);
  logic [DATA_W-1:0] mem_q [NUM_BANKS][DEPTH];
  logic [CNT_W-1:0]  cnt_q [NUM_BANKS];
  logic [NUM_BANKS-1:0] full_q;

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[fill_bank_i][wr_idx_i] <= wr_data_i;
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        full_q[b] <= 1'b0;
        cnt_q[b]  <= '0;
      end else if (commit_i && fill_bank_i == bank_sel_t'(b)) begin
        full_q[b] <= 1'b1;
        cnt_q[b]  <= commit_cnt_i;
      end else if (release_i && sel_i == bank_sel_t'(b)) begin
        full_q[b] <= 1'b0;
      end
    end

    assert_cnt_bound_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      full_q[b] |-> cnt_q[b] <= CNT_W'(DEPTH));
  end

  assign full_o    = full_q;
  assign cnt_sel_o = cnt_q[sel_i];
  assign rd_data_o = mem_q[sel_i][rd_idx_i];

  assert_commit_free_bank_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |-> !full_q[fill_bank_i]);
  assert_release_full_bank_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_i |-> full_q[sel_i]);
endmodule

// File: rtl/rx_drain_ctrl.sv
module rx_drain_ctrl
  import rx_dma_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CNT_W = $clog2(DEPTH + 1),
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 dma_en_i,
  input  logic                 dma_ack_i,
  input  logic                 cpu_rd_i,
  input  logic                 cpu_done_i,
  input  logic [NUM_BANKS-1:0] full_i,
  input  logic [CNT_W-1:0]     cnt_i,
  output bank_sel_t            sel_o,
  output logic [IDX_W-1:0]     rd_idx_o,
  output logic                 release_o,
  output logic                 rx_full_o,
  output logic                 dma_req_o,
  output logic                 auto_rel_o,
  output logic                 proto_err_o
);
  bank_sel_t        sel_q;
  logic [CNT_W-1:0] rd_q;
  logic             have, pop, last, auto_rel, manual_rel;
  logic             auto_rel_q, err_q;

  assign rx_full_o  = full_i[sel_q];
  assign have       = rx_full_o && (rd_q < cnt_i);
  assign dma_req_o  = dma_en_i && have;
  assign pop        = (dma_en_i ? dma_ack_i : cpu_rd_i) && have;
  assign last       = pop && (rd_q + CNT_W'(1) == cnt_i);
  assign auto_rel   = dma_en_i && last;
  // read-done from software only acts in CPU mode
  assign manual_rel = !dma_en_i && cpu_done_i && rx_full_o;
  assign release_o  = auto_rel || manual_rel;
  assign sel_o      = sel_q;
  assign rd_idx_o   = rd_q[IDX_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q      <= 1'b0;
      rd_q       <= '0;
      auto_rel_q <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      auto_rel_q <= auto_rel;
      err_q      <= dma_en_i && cpu_done_i;
      if (release_o) begin
        sel_q <= other_bank(sel_q);
        rd_q  <= '0;
      end else if (pop) begin
        rd_q <= rd_q + CNT_W'(1);
      end
    end
  end

  assign auto_rel_o  = auto_rel_q;
  assign proto_err_o = err_q;

  assert_auto_rel_in_dma_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    auto_rel_o |-> $past(dma_en_i));
  assert_auto_rel_switches_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    auto_rel_o |-> sel_q != $past(sel_q));
  assert_err_in_dma_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    proto_err_o |-> $past(dma_en_i && cpu_done_i));
  assert_req_only_full_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_o |-> full_i[sel_q] && dma_en_i);
endmodule

// File: rtl/rx_dma_drain.sv
module rx_dma_drain
  import rx_dma_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dma_en_i,
  input  logic              wr_valid_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              pkt_end_i,
  output logic              wr_ready_o,
  input  logic              dma_ack_i,
  input  logic              cpu_rd_i,
  input  logic              cpu_done_i,
  output logic              dma_req_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rx_full_o,
  output logic [CNT_W-1:0]  rx_cnt_o,
  output logic              auto_rel_o,
  output logic              proto_err_o
);
  logic [NUM_BANKS-1:0] full;
  logic                 wr_en, commit, release_b;
  logic [IDX_W-1:0]     wr_idx, rd_idx;
  logic [CNT_W-1:0]     commit_cnt;
  bank_sel_t            fill_bank, sel;

  rx_fill_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_fill (
    .clk_i, .rst_ni, .dma_en_i, .wr_valid_i, .pkt_end_i,
    .bank_full_i (full),
    .wr_ready_o,
    .wr_en_o     (wr_en),
    .wr_idx_o    (wr_idx),
    .fill_bank_o (fill_bank),
    .commit_o    (commit),
    .commit_cnt_o(commit_cnt)
  );

  rx_bank_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_store (
    .clk_i, .rst_ni,
    .wr_en_i     (wr_en),
    .fill_bank_i (fill_bank),
    .wr_idx_i    (wr_idx),
    .wr_data_i,
    .commit_i    (commit),
    .commit_cnt_i(commit_cnt),
    .release_i   (release_b),
    .sel_i       (sel),
    .rd_idx_i    (rd_idx),
    .full_o      (full),
    .cnt_sel_o   (rx_cnt_o),
    .rd_data_o
  );

  rx_drain_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_drain (
    .clk_i, .rst_ni, .dma_en_i, .dma_ack_i, .cpu_rd_i, .cpu_done_i,
    .full_i    (full),
    .cnt_i     (rx_cnt_o),
    .sel_o     (sel),
    .rd_idx_o  (rd_idx),
    .release_o (release_b),
    .rx_full_o,
    .dma_req_o,
    .auto_rel_o,
    .proto_err_o
  );
endmodule

// File: tb/tb_rx_dma_drain.sv
module tb_rx_dma_drain;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dma_en = 1'b0, wr_valid = 1'b0, pkt_end = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       dma_ack = 1'b0, cpu_rd = 1'b0, cpu_done = 1'b0;
  logic       wr_ready, dma_req, rx_full, auto_rel, proto_err;
  logic [7:0] rd_data;
  logic [6:0] rx_cnt;

  int compared = 0, mismatched = 0, cycles = 0, auto_seen = 0, err_seen = 0;
  bit done = 0;

  // reference model state
  logic [7:0] wq[$];
  logic [7:0] pd[$];
  int         pl[$];
  int         used = 0;
  bit         e_auto = 0, e_err = 0;

  always #2 clk = ~clk;

  rx_dma_drain dut (
    .clk_i(clk), .rst_ni(rst_n), .dma_en_i(dma_en), .wr_valid_i(wr_valid),
    .wr_data_i(wr_data), .pkt_end_i(pkt_end), .wr_ready_o(wr_ready),
    .dma_ack_i(dma_ack), .cpu_rd_i(cpu_rd), .cpu_done_i(cpu_done),
    .dma_req_o(dma_req), .rd_data_o(rd_data), .rx_full_o(rx_full),
    .rx_cnt_o(rx_cnt), .auto_rel_o(auto_rel), .proto_err_o(proto_err)
  );

  always @(posedge clk) cycles++;

  task automatic chk(bit ok, string tag, int act, int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cycles);
    end
  endtask

  task automatic compare();
    bit full_e = pl.size() > 0;
    bit hv = full_e && used < pl[0];
    chk(wr_ready === (pl.size() < 2), "R8 wr_ready", int'(wr_ready), int'(pl.size() < 2));
    chk(rx_full === full_e, "R7 rx_full", int'(rx_full), int'(full_e));
    chk(dma_req === (dma_en && hv), "R1 dma_req", int'(dma_req), int'(dma_en && hv));
    if (hv) chk(rd_data === pd[0], "R2 rd_data", int'(rd_data), int'(pd[0]));
    if (full_e) chk(rx_cnt === 7'(pl[0]), "R9 rx_cnt", int'(rx_cnt), pl[0]);
    chk(auto_rel === e_auto, "R3 auto_rel", int'(auto_rel), int'(e_auto));
    chk(proto_err === e_err, "R6 proto_err", int'(proto_err), int'(e_err));
    if (auto_rel === 1'b1) auto_seen++;
    if (proto_err === 1'b1) err_seen++;
  endtask

  task automatic model_edge();
    int  n = pl.size();
    bit  rdy = n < 2;
    bit  hv = n > 0 && used < pl[0];
    bit  pop = (dma_en ? dma_ack : cpu_rd) && hv;
    bit  last = pop && (used + 1 == pl[0]);
    bit  rel = dma_en ? last : (cpu_done && n > 0);
    e_auto = dma_en && last;
    e_err  = dma_en && cpu_done;
    if (pop) begin void'(pd.pop_front()); used++; end
    if (rel) begin
      repeat (pl[0] - used) void'(pd.pop_front());
      void'(pl.pop_front());
      used = 0;
    end
    if (wr_valid && rdy && wq.size() < 64) wq.push_back(wr_data);
    if (pkt_end && rdy) begin
      if (!(dma_en && wq.size() == 0)) begin
        pl.push_back(wq.size());
        foreach (wq[i]) pd.push_back(wq[i]);
      end
      wq.delete();
    end
  endtask

  task automatic tick();
    #1 compare();
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic send(int len, int base);
    for (int i = 0; i < len; i++) begin
      wr_valid = 1'b1;
      wr_data  = 8'(base + i);
      tick();
    end
    wr_valid = 1'b0;
    pkt_end  = 1'b1;
    tick();
    pkt_end  = 1'b0;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    wait (cycles > 20000);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R10 reset state
    chk(wr_ready === 1'b1 && dma_req === 1'b0 && rx_full === 1'b0, "R10 reset outputs",
        int'({wr_ready, dma_req, rx_full}), 4);
    chk(auto_rel === 1'b0 && proto_err === 1'b0, "R10 reset pulses",
        int'({auto_rel, proto_err}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R4: 150 bytes as 64/64/22 drained by DMA
    dma_en = 1'b1; dma_ack = 1'b1; auto_seen = 0;
    send(64, 8'h10);
    send(64, 8'h60);
    send(22, 8'hB0);
    idle(80);
    chk(auto_seen == 3, "R4 auto releases", auto_seen, 3);
    chk(rx_full === 1'b0, "R4 banks empty", int'(rx_full), 0);

    // R5 zero-length in DMA mode
    dma_ack = 1'b0;
    send(0, 0);
    idle(3);
    chk(rx_full === 1'b0 && dma_req === 1'b0, "R5 zlp dropped", int'({rx_full, dma_req}), 0);

    // R6 read-done in DMA mode ignored and flagged
    send(1, 8'h5A);
    err_seen = 0;
    cpu_done = 1'b1; tick(); cpu_done = 1'b0;
    idle(2);
    chk(err_seen == 1, "R6 error pulses", err_seen, 1);
    chk(rx_full === 1'b1 && rd_data === 8'h5A, "R6 bank kept", int'(rd_data), 8'h5A);
    dma_ack = 1'b1; idle(4); dma_ack = 1'b0;

    // R8 both banks full blocks writes
    send(10, 8'h20);
    send(20, 8'h40);
    #1 chk(wr_ready === 1'b0, "R8 both full", int'(wr_ready), 0);
    @(negedge clk);
    send(5, 8'hE0);
    dma_ack = 1'b1; idle(40); dma_ack = 1'b0;

    // R9 oversize packet saturates at 64
    send(70, 8'h80);
    #1 chk(rx_cnt === 7'd64, "R9 saturate", int'(rx_cnt), 64);
    @(negedge clk);
    dma_ack = 1'b1; idle(70); dma_ack = 1'b0;

    // R7 CPU mode: no auto release, manual release
    dma_en = 1'b0;
    send(5, 8'hC0);
    dma_ack = 1'b1; cpu_rd = 1'b1; idle(7); cpu_rd = 1'b0; dma_ack = 1'b0;
    #1 chk(rx_full === 1'b1, "R7 no auto release", int'(rx_full), 1);
    @(negedge clk);
    cpu_done = 1'b1; tick(); cpu_done = 1'b0;
    #1 chk(rx_full === 1'b0, "R7 manual release", int'(rx_full), 0);
    @(negedge clk);

    // R11 zero-length committed in CPU mode
    send(0, 0);
    #1 chk(rx_full === 1'b1 && rx_cnt === 7'd0, "R11 zlp kept", int'(rx_cnt), 0);
    @(negedge clk);
    cpu_done = 1'b1; tick(); cpu_done = 1'b0;
    idle(3);

    done = 1;
    finish_run();
  end
endmodule